// File: doc/BRIEF.md
# Programmable Memory-Controller Pattern Dispatcher

This block sits inside a programmable memory controller. It picks a microcode pattern from a 64-word pattern store and steps through it. A request can come from one of six classes: read or write access (each single-beat or burst), a refresh tick, or an exception. Each class enters the store at its own fixed word. A software run command is different: it names its own start word, which may be any entry of the store. Once a pattern starts, the dispatcher presents one stored word per clock on its control output. It stops after the word whose lowest bit is set, then pulses a completion flag.

Only one pattern runs at a time. The exception input (soft reset or transfer error) is the single exception to that rule. It cuts a running pattern short and branches to the exception pattern, which cannot itself be cut short. Accesses that arrive on the secondary bus but hit a bank owned by the primary bus start nothing. A host port loads the store while the dispatcher is idle. A write that arrives during a pattern is discarded and reported.

Top module: `pattern_dispatch`

## Requirements
- R1: When idle, an accepted access starts at a fixed word chosen by its type. acc_write=0/acc_burst=0 starts at 0x00, acc_write=0/acc_burst=1 at 0x08, acc_write=1/acc_burst=0 at 0x18, and acc_write=1/acc_burst=1 at 0x20.
- R2: When idle, a refresh request starts the pattern at word 0x30.
- R3: When idle, a run command starts the pattern at the word given on run_word, which may be any of the 64 words.
- R4: While a pattern other than the exception pattern runs, exc_soft or exc_err makes the next presented word 0x3C. This holds even when the current word carries the last flag.
- R5: An exception input while idle starts nothing. An exception input during the exception pattern has no effect, and the pattern runs on in sequence.
- R6: If several requests arrive together while idle, refresh wins over run, and run wins over access. Any request seen while a pattern is running is dropped.
- R7: An access with acc_from_sec=1 and acc_bank_sec=0 is ignored. An access with acc_from_sec=0, or with acc_bank_sec=1, is accepted.
- R8: A pattern presents one word per clock, with busy=1, cur_idx set to the word index and ctrl_out set to the stored word. It ends after the word whose bit 0 is 1. On the next cycle busy=0, done=1 for exactly one cycle, and ctrl_out=0.
- R9: The word index advances from 63 to 0 when no last flag has been reached.
- R10: A host write while idle updates the store. A host write while busy=1 leaves the store unchanged and gives wr_err=1 on the following cycle.
- R11: After reset, busy, done and wr_err are 0 and ctrl_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_req | input | 1 | Memory access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_burst | input | 1 | 1 = burst, 0 = single beat |
| acc_from_sec | input | 1 | Request came from the secondary bus |
| acc_bank_sec | input | 1 | Addressed bank is assigned to the secondary bus |
| rfsh_req | input | 1 | Refresh timer request |
| exc_soft | input | 1 | Soft-reset exception |
| exc_err | input | 1 | Transfer-error exception |
| run_req | input | 1 | Software run command |
| run_word | input | 6 | Start word of the run command |
| host_we | input | 1 | Host write strobe for the pattern store |
| host_addr | input | 6 | Host write word index |
| host_wdata | input | 32 | Host write data |
| busy | output | 1 | A pattern is being presented |
| cur_idx | output | 6 | Index of the presented word |
| ctrl_out | output | 32 | Presented control word, 0 when idle |
| done | output | 1 | One-cycle pulse after the last word |
| wr_err | output | 1 | One-cycle pulse after a dropped host write |

## Verification
A wrong entry point or a corrupt sequencer index shows up at cur_idx and ctrl_out on the first cycle after the request. This is because every presented word is compared against the bench's own copy of the store. If the in-exception state is wrong, a second exception either sends the index back to 0x3C or fails to branch. Either way the error appears one cycle after the exception input. A write that slipped into the store during a pattern shows up the next time that word is presented, because the bench model keeps the old value.

// File: rtl/pdisp_pkg.sv
package pdisp_pkg;

    // Bit of each stored word that ends a pattern.
    localparam int LAST_BIT = 0;

    // Request classes seen by the arbiter.
    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_RD_SGL,
        CLS_RD_BST,
        CLS_WR_SGL,
        CLS_WR_BST,
        CLS_RFSH,
        CLS_RUN
    } req_cls_e;

endpackage

// File: rtl/pdisp_ram.sv
module pdisp_ram #(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Asynchronous read: the sequencer index selects the presented word.
    assign rdata = mem_q[raddr];

endmodule

// File: rtl/pdisp_arb.sv
module pdisp_arb
    import pdisp_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int IDX_RSS = 'h00,
    parameter int IDX_RBS = 'h08,
    parameter int IDX_WSS = 'h18,
    parameter int IDX_WBS = 'h20,
    parameter int IDX_PTS = 'h30,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic          acc_req,
    input  logic          acc_write,
    input  logic          acc_burst,
    input  logic          acc_from_sec,
    input  logic          acc_bank_sec,
    input  logic          rfsh_req,
    input  logic          run_req,
    input  logic [AW-1:0] run_word,
    output logic          start,
    output logic [AW-1:0] start_idx
);

    req_cls_e cls;
    logic     acc_ok;

    // Secondary-bus accesses into a primary-owned bank are dropped.
    assign acc_ok = acc_req && !(acc_from_sec && !acc_bank_sec);

    always_comb begin
        if (rfsh_req) begin
            cls = CLS_RFSH;
        end else if (run_req) begin
            cls = CLS_RUN;
        end else if (acc_ok) begin
            case ({acc_write, acc_burst})
                2'b00:   cls = CLS_RD_SGL;
                2'b01:   cls = CLS_RD_BST;
                2'b10:   cls = CLS_WR_SGL;
                default: cls = CLS_WR_BST;
            endcase
        end else begin
            cls = CLS_NONE;
        end
    end

    always_comb begin
        start = (cls != CLS_NONE);
        case (cls)
            CLS_RD_SGL: start_idx = AW'(IDX_RSS);
            CLS_RD_BST: start_idx = AW'(IDX_RBS);
            CLS_WR_SGL: start_idx = AW'(IDX_WSS);
            CLS_WR_BST: start_idx = AW'(IDX_WBS);
            CLS_RFSH:   start_idx = AW'(IDX_PTS);
            CLS_RUN:    start_idx = run_word;
            default:    start_idx = '0;
        endcase
    end

endmodule

// File: rtl/pdisp_seq.sv
module pdisp_seq #(
    parameter int DEPTH   = 64,
    parameter int IDX_EXS = 'h3C,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_idx,
    input  logic          exc,
    input  logic          word_last,
    input  logic          host_we,
    output logic          busy,
    output logic          in_exc,
    output logic [AW-1:0] idx,
    output logic          done,
    output logic          wr_err,
    output logic          ram_we
);

    typedef struct packed {
        logic          busy;
        logic          in_exc;
        logic [AW-1:0] idx;
        logic          done;
        logic          wr_err;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.wr_err = host_we && st_q.busy;
        if (st_q.busy) begin
            if (exc && !st_q.in_exc) begin
                st_d.idx    = AW'(IDX_EXS);
                st_d.in_exc = 1'b1;
            end else if (word_last) begin
                st_d.busy   = 1'b0;
                st_d.in_exc = 1'b0;
                st_d.done   = 1'b1;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end else if (start) begin
            st_d.busy   = 1'b1;
            st_d.in_exc = 1'b0;
            st_d.idx    = start_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = st_q.busy;
    assign in_exc = st_q.in_exc;
    assign idx    = st_q.idx;
    assign done   = st_q.done;
    assign wr_err = st_q.wr_err;
    assign ram_we = host_we && !st_q.busy;

endmodule

// File: rtl/pattern_dispatch.sv
module pattern_dispatch #(
    parameter int DEPTH   = 64,
    parameter int DW      = 32,
    parameter int IDX_RSS = 'h00,
    parameter int IDX_RBS = 'h08,
    parameter int IDX_WSS = 'h18,
    parameter int IDX_WBS = 'h20,
    parameter int IDX_PTS = 'h30,
    parameter int IDX_EXS = 'h3C,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_req,
    input  logic          acc_write,
    input  logic          acc_burst,
    input  logic          acc_from_sec,
    input  logic          acc_bank_sec,
    input  logic          rfsh_req,
    input  logic          exc_soft,
    input  logic          exc_err,
    input  logic          run_req,
    input  logic [AW-1:0] run_word,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic          busy,
    output logic [AW-1:0] cur_idx,
    output logic [DW-1:0] ctrl_out,
    output logic          done,
    output logic          wr_err
);

    logic          start;
    logic [AW-1:0] start_idx;
    logic          in_exc;
    logic          ram_we;
    logic [DW-1:0] rdata;

    pdisp_arb #(
        .DEPTH  (DEPTH),
        .IDX_RSS(IDX_RSS),
        .IDX_RBS(IDX_RBS),
        .IDX_WSS(IDX_WSS),
        .IDX_WBS(IDX_WBS),
        .IDX_PTS(IDX_PTS)
    ) u_arb (
        .acc_req     (acc_req),
        .acc_write   (acc_write),
        .acc_burst   (acc_burst),
        .acc_from_sec(acc_from_sec),
        .acc_bank_sec(acc_bank_sec),
        .rfsh_req    (rfsh_req),
        .run_req     (run_req),
        .run_word    (run_word),
        .start       (start),
        .start_idx   (start_idx)
    );

    pdisp_seq #(
        .DEPTH  (DEPTH),
        .IDX_EXS(IDX_EXS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .start_idx(start_idx),
        .exc      (exc_soft || exc_err),
        .word_last(rdata[pdisp_pkg::LAST_BIT]),
        .host_we  (host_we),
        .busy     (busy),
        .in_exc   (in_exc),
        .idx      (cur_idx),
        .done     (done),
        .wr_err   (wr_err),
        .ram_we   (ram_we)
    );

    pdisp_ram #(
        .DEPTH(DEPTH),
        .DW   (DW)
    ) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .waddr(host_addr),
        .wdata(host_wdata),
        .raddr(cur_idx),
        .rdata(rdata)
    );

    assign ctrl_out = busy ? rdata : '0;

endmodule

// File: rtl/pattern_dispatch_chk.sv
module pattern_dispatch_chk #(
    parameter int AW      = 6,
    parameter int DW      = 32,
    parameter int IDX_PTS = 'h30,
    parameter int IDX_EXS = 'h3C
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          in_exc,
    input logic          done,
    input logic          wr_err,
    input logic [AW-1:0] cur_idx,
    input logic [DW-1:0] ctrl_out,
    input logic          exc_soft,
    input logic          exc_err,
    input logic          rfsh_req,
    input logic          run_req,
    input logic [AW-1:0] run_word,
    input logic          acc_req,
    input logic          host_we
);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy) && $past(ctrl_out[0])));

    a_r4_exc_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !in_exc && (exc_soft || exc_err)) |=> (busy && in_exc && cur_idx == AW'(IDX_EXS)));

    a_r5_idle_exc_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (exc_soft || exc_err) && !rfsh_req && !run_req && !acc_req) |=> !busy);

    a_r9_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ctrl_out[0] && !((exc_soft || exc_err) && !in_exc))
        |=> (busy && cur_idx == AW'($past(cur_idx) + 1'b1)));

    a_r10_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_we) |=> wr_err);

    a_r2_refresh_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rfsh_req) |=> (busy && cur_idx == AW'(IDX_PTS)));

    a_r3_run_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && run_req && !rfsh_req) |=> (busy && cur_idx == $past(run_word)));

    a_r11_idle_output: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ctrl_out == '0));

endmodule

bind pattern_dispatch pattern_dispatch_chk #(
    .AW     (AW),
    .DW     (DW),
    .IDX_PTS(IDX_PTS),
    .IDX_EXS(IDX_EXS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .in_exc  (in_exc),
    .done    (done),
    .wr_err  (wr_err),
    .cur_idx (cur_idx),
    .ctrl_out(ctrl_out),
    .exc_soft(exc_soft),
    .exc_err (exc_err),
    .rfsh_req(rfsh_req),
    .run_req (run_req),
    .run_word(run_word),
    .acc_req (acc_req),
    .host_we (host_we)
);

// File: tb/pattern_dispatch_test.sv
`timescale 1ns/1ps
module pattern_dispatch_test;

    localparam int DEPTH = 64;
    localparam int DW    = 32;
    localparam int AW    = 6;
    localparam int EXS   = 'h3C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_req = 0, acc_write = 0, acc_burst = 0;
    logic          acc_from_sec = 0, acc_bank_sec = 0;
    logic          rfsh_req = 0, exc_soft = 0, exc_err = 0, run_req = 0;
    logic [AW-1:0] run_word = '0;
    logic          host_we = 0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          busy, done, wr_err;
    logic [AW-1:0] cur_idx;
    logic [DW-1:0] ctrl_out;

    int errs = 0;
    int checks = 0;
    logic [DW-1:0] model [DEPTH];

    always #2.5 clk = ~clk;

    pattern_dispatch uut (
        .clk(clk), .rst_n(rst_n),
        .acc_req(acc_req), .acc_write(acc_write), .acc_burst(acc_burst),
        .acc_from_sec(acc_from_sec), .acc_bank_sec(acc_bank_sec),
        .rfsh_req(rfsh_req), .exc_soft(exc_soft), .exc_err(exc_err),
        .run_req(run_req), .run_word(run_word),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .busy(busy), .cur_idx(cur_idx), .ctrl_out(ctrl_out),
        .done(done), .wr_err(wr_err)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_reqs();
        acc_req = 0; acc_write = 0; acc_burst = 0;
        acc_from_sec = 0; acc_bank_sec = 0;
        rfsh_req = 0; run_req = 0; run_word = '0;
    endtask

    function automatic int exp_start(bit rf, bit rn, int rw, bit ac, bit wr, bit bu, bit fs, bit bs);
        if (rf) return 'h30;
        if (rn) return rw;
        if (ac && !(fs && !bs)) begin
            case ({wr, bu})
                2'b00:   return 'h00;
                2'b01:   return 'h08;
                2'b10:   return 'h18;
                default: return 'h20;
            endcase
        end
        return -1;
    endfunction

    task automatic write_word(input int a, input logic [DW-1:0] d);
        host_we = 1; host_addr = AW'(a); host_wdata = d;
        @(negedge clk);
        host_we = 0;
        model[a] = d;
        chk(wr_err == 1'b0, "R10 idle write no error", wr_err, 0);
    endtask

    // Follows a running pattern from its first presented word.
    task automatic follow(input int start, input int exc_step, input int blk_step,
                          input int blk_addr, input bit noise, input string tag);
        int  idx = start;
        bit  inx = 0;
        bit  fin = 0;
        for (int step = 0; step < 300 && !fin; step++) begin
            bit last;
            bit exc_now;
            chk(busy == 1'b1, {tag, " R8 busy"}, busy, 1);
            chk(cur_idx == AW'(idx), {tag, " R8/R9 index"}, cur_idx, idx);
            chk(ctrl_out == model[idx], {tag, " R8 word"}, ctrl_out, model[idx]);
            last = model[idx][0];
            exc_now = (exc_step >= 0) && (step >= exc_step);
            exc_soft = exc_now && step[0];
            exc_err  = exc_now && !step[0];
            if (noise) begin
                rfsh_req = 1'($urandom_range(0, 1));
                run_req  = 1'($urandom_range(0, 1));
                run_word = AW'($urandom_range(0, 63));
                acc_req  = 1'($urandom_range(0, 1));
            end
            if (step == blk_step) begin
                host_we = 1; host_addr = AW'(blk_addr); host_wdata = ~model[blk_addr];
            end
            if (exc_now && !inx) begin
                idx = EXS; inx = 1;
            end else if (last) begin
                fin = 1;
            end else begin
                idx = (idx + 1) % DEPTH;
            end
            @(negedge clk);
            exc_soft = 0; exc_err = 0;
            if (step == blk_step) begin
                host_we = 0;
                chk(wr_err == 1'b1, {tag, " R10 blocked write flagged"}, wr_err, 1);
            end
        end
        clear_reqs();
        chk(fin, {tag, " R8 pattern terminated"}, fin, 1);
        chk(busy == 1'b0 && done == 1'b1, {tag, " R8 done pulse"}, {busy, done}, 2'b01);
        chk(ctrl_out == '0, {tag, " R8 idle output"}, ctrl_out, 0);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R8 done one cycle"}, done, 0);
    endtask

    task automatic launch(input bit rf, input bit rn, input int rw, input bit ac,
                          input bit wr, input bit bu, input bit fs, input bit bs,
                          input bit ex_idle, input int exc_step, input int blk_step,
                          input int blk_addr, input bit noise, input string tag);
        int e;
        rfsh_req = rf; run_req = rn; run_word = AW'(rw);
        acc_req = ac; acc_write = wr; acc_burst = bu;
        acc_from_sec = fs; acc_bank_sec = bs;
        exc_soft = ex_idle;
        @(negedge clk);
        clear_reqs();
        exc_soft = 0;
        e = exp_start(rf, rn, rw, ac, wr, bu, fs, bs);
        if (e < 0) begin
            chk(busy == 1'b0, {tag, " no pattern started"}, busy, 0);
            chk(ctrl_out == '0, {tag, " output stays idle"}, ctrl_out, 0);
        end else begin
            follow(e, exc_step, blk_step, blk_addr, noise, tag);
        end
    endtask

    function automatic bit dir_flag(int i);
        return i == 'h03 || i == 'h0F || i == 'h18 || i == 'h27 ||
               i == 'h31 || i == 'h3E || i == 'h2C;
    endfunction

    initial begin
        #(5.0 * 150000);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        chk(busy == 0, "R11 reset busy", busy, 0);
        chk(done == 0, "R11 reset done", done, 0);
        chk(wr_err == 0, "R11 reset wr_err", wr_err, 0);
        chk(ctrl_out == '0, "R11 reset ctrl_out", ctrl_out, 0);
        rst_n = 1;
        @(negedge clk);

        for (int i = 0; i < DEPTH; i++)
            write_word(i, {31'($urandom), dir_flag(i)});

        // R1 entry points for the four access types, primary bus
        launch(0,0,0, 1,0,0, 0,0, 0, -1,-1,0, 0, "R1 read single");
        launch(0,0,0, 1,0,1, 0,0, 0, -1,-1,0, 0, "R1 read burst");
        launch(0,0,0, 1,1,0, 0,0, 0, -1,-1,0, 0, "R1 write single");
        launch(0,0,0, 1,1,1, 0,1, 0, -1,-1,0, 0, "R1 write burst");
        // R7 secondary-bus filtering
        launch(0,0,0, 1,0,1, 1,0, 0, -1,-1,0, 0, "R7 secondary into primary bank");
        launch(0,0,0, 1,1,1, 1,1, 0, -1,-1,0, 0, "R7 secondary into own bank");
        // R2 refresh, R3 run with R9 wrap
        launch(1,0,0, 0,0,0, 0,0, 0, -1,-1,0, 0, "R2 refresh");
        launch(0,1,'h3F, 0,0,0, 0,0, 0, -1,-1,0, 0, "R3 R9 run wrap");
        launch(0,1,'h2A, 0,0,0, 0,0, 0, -1,-1,0, 1, "R3 run mid with R6 noise");
        // R6 priority
        launch(1,1,'h2A, 1,1,1, 0,0, 0, -1,-1,0, 0, "R6 refresh over all");
        launch(0,1,'h10, 1,0,0, 0,0, 0, -1,-1,0, 1, "R6 run over access");
        // R5 exception while idle
        launch(0,0,0, 0,0,0, 0,0, 1, -1,-1,0, 0, "R5 idle exception");
        // R4 abort mid-pattern, exception held to test R5 re-abort
        launch(0,0,0, 1,0,1, 0,0, 0, 2,-1,0, 0, "R4 R5 abort and hold");
        // R4 abort on the last word of a single-word pattern
        launch(0,0,0, 1,1,0, 0,0, 0, 0,-1,0, 0, "R4 abort at last word");
        // R10 blocked write then re-read
        launch(0,0,0, 1,0,1, 0,0, 0, -1,0,9, 0, "R10 write during run");
        launch(0,0,0, 1,0,1, 0,0, 0, -1,-1,0, 0, "R10 store unchanged");

        // Random phase
        for (int i = 0; i < DEPTH; i++)
            write_word(i, {31'($urandom), ($urandom_range(0, 3) == 0) || i == 63});
        for (int n = 0; n < 60; n++) begin
            launch(($urandom_range(0, 3) == 0), ($urandom_range(0, 2) == 0),
                   $urandom_range(0, 63), 1'($urandom_range(0, 1)),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                   ($urandom_range(0, 5) == 0),
                   ($urandom_range(0, 2) == 0) ? $urandom_range(0, 4) : -1,
                   ($urandom_range(0, 3) == 0) ? $urandom_range(0, 2) : -1,
                   $urandom_range(0, 63), 1'($urandom_range(0, 1)),
                   "R1 R6 R8 random");
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule